// File: doc/BRIEF.md
# Shared-Pin Parallel I/O Port

This block controls a parallel port of `W` pins (eight by default). For every pin it keeps five bits of state, written and read over a small register bus: an output data latch, a direction bit, a pull-up request, a slew-limit request and a strong-drive request. From this state and the pin's ownership it produces the controls for each pad: output value, output enable, input-buffer enable, pull-up, slew and drive. It also takes the pad input values.

Two ownership vectors arrive from the rest of the chip. A digital peripheral that claims a pin takes over that pin's output value and output enable. An analog claim turns off both the input and output buffers. If both claims are set on one pin, the analog claim wins. Port-data reads follow the direction bit in every case. When the direction bit is 1 the read returns the latch. When it is 0 the read returns the pad input after a two-flop synchronizer, or 0 if that pin's input buffer is off. Pins named in the `OUT_ONLY` mask never have an input buffer.

The reset input is asynchronous and active low, and its release is synchronized inside the block. Until that release has passed through, both ownership vectors are ignored.

Top module: `gpio_share_port`

## Requirements
- R1: After reset, all five per-pin registers read 0. Because every direction bit is 0, pad_oe is 0 on every pin.
- R2: While the internally synchronized reset is still low (two rising edges after rst_n rises), per_en and ana_en have no effect. In that time pad_oe is 0 and pad_ie equals ~OUT_ONLY.
- R3: A rising edge with wr_en high writes wdata to the register at addr. The offsets are 0 data latch, 1 direction, 2 pull-up, 3 slew, 4 drive. Offsets 5 to 7 store nothing and read 0. Reads are combinational.
- R4: On a pin with no claim, pad_oe equals its direction bit and pad_out equals its data-latch bit.
- R5: At offset 0, a pin with direction 1 reads its data-latch bit. A pin with direction 0 reads its pad input, which appears after the second rising edge that follows a change.
- R6: On a pin with per_en set and ana_en clear, pad_out equals per_out and pad_oe equals per_oe. The offset-0 read still follows the direction bit.
- R7: On a pin with ana_en set, pad_oe, pad_ie and pad_out are 0, whatever per_en holds.
- R8: pad_ie is 1 unless the pin is analog or its bit in OUT_ONLY is set. A direction-0 pin whose pad_ie is 0 reads 0 at offset 0.
- R9: pad_pu equals the pull-up bit ANDed with ~pad_oe and ANDed with "not analog".
- R10: pad_slew and pad_drive equal the slew and drive registers in every ownership mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register offset |
| wdata | input | W | Write data |
| rdata | output | W | Combinational read data |
| per_en | input | W | Digital peripheral claims the pin |
| per_out | input | W | Peripheral output value |
| per_oe | input | W | Peripheral output enable |
| ana_en | input | W | Analog function claims the pin |
| pad_in | input | W | Pad input values |
| pad_out | output | W | Pad output value |
| pad_oe | output | W | Pad output-buffer enable |
| pad_ie | output | W | Pad input-buffer enable |
| pad_pu | output | W | Pad pull-up enable |
| pad_slew | output | W | Pad slew-limit enable |
| pad_drive | output | W | Pad strong-drive enable |

## Verification
Two events can land in the same cycle: a register write to the direction or data latch, and a change of pin ownership through per_en or ana_en. A further case is a pad input toggling while its direction bit flips. The directed phase writes the direction register in the same cycle that a peripheral releases or claims pins. A random phase then drives writes, ownership vectors and pad values together on every cycle. In both phases a behavioural model built from the requirements judges pad_oe, pad_out, pad_ie, pad_pu and the read data after every edge. The model tracks the two-cycle input latency with its own delay stages.

// File: rtl/gpio_share_pkg.sv
package gpio_share_pkg;
  localparam int unsigned REG_AW   = 3;
  localparam int unsigned NUM_REGS = 5;

  typedef enum logic [REG_AW-1:0] {
    OFF_DATA  = 3'd0,
    OFF_DIR   = 3'd1,
    OFF_PULL  = 3'd2,
    OFF_SLEW  = 3'd3,
    OFF_DRIVE = 3'd4
  } reg_off_e;
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb stage_d = {stage_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= stage_d;
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      hold_q <= '0;
    end else begin
      meta_q <= d;
      hold_q <= meta_q;
    end
  end

  assign q = hold_q;
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_share_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      data_q,
  output logic [W-1:0]      dir_q,
  output logic [W-1:0]      pull_q,
  output logic [W-1:0]      slew_q,
  output logic [W-1:0]      drive_q
);
  logic [W-1:0]        regs_q [NUM_REGS];
  logic [W-1:0]        regs_d [NUM_REGS];
  logic [NUM_REGS-1:0] wr_sel;

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    always_comb begin
      wr_sel[r] = wr_en && (addr == REG_AW'(r));
      regs_d[r] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         regs_q[r] <= '0;
      else if (wr_sel[r]) regs_q[r] <= regs_d[r];
    end
  end

  assign data_q  = regs_q[OFF_DATA];
  assign dir_q   = regs_q[OFF_DIR];
  assign pull_q  = regs_q[OFF_PULL];
  assign slew_q  = regs_q[OFF_SLEW];
  assign drive_q = regs_q[OFF_DRIVE];
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux #(
  parameter bit NO_INPUT = 1'b0
) (
  input  logic data,
  input  logic dir,
  input  logic pull,
  input  logic per_en,
  input  logic per_out,
  input  logic per_oe,
  input  logic ana_en,
  input  logic sync_in,
  output logic pad_out,
  output logic pad_oe,
  output logic pad_ie,
  output logic pad_pu,
  output logic rd_bit
);
  logic dig_own;

  always_comb begin
    dig_own = per_en && !ana_en;
    if (ana_en) begin
      pad_out = 1'b0;
      pad_oe  = 1'b0;
      pad_ie  = 1'b0;
    end else if (dig_own) begin
      pad_out = per_out;
      pad_oe  = per_oe;
      pad_ie  = !NO_INPUT;
    end else begin
      pad_out = data;
      pad_oe  = dir;
      pad_ie  = !NO_INPUT;
    end
    pad_pu = pull && !pad_oe && !ana_en;
    rd_bit = dir ? data : (sync_in && pad_ie);
  end
endmodule

// File: rtl/gpio_share_port.sv
module gpio_share_port
  import gpio_share_pkg::*;
#(
  parameter int unsigned W        = 8,
  parameter logic [W-1:0] OUT_ONLY = 8'h80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      rdata,
  input  logic [W-1:0]      per_en,
  input  logic [W-1:0]      per_out,
  input  logic [W-1:0]      per_oe,
  input  logic [W-1:0]      ana_en,
  input  logic [W-1:0]      pad_in,
  output logic [W-1:0]      pad_out,
  output logic [W-1:0]      pad_oe,
  output logic [W-1:0]      pad_ie,
  output logic [W-1:0]      pad_pu,
  output logic [W-1:0]      pad_slew,
  output logic [W-1:0]      pad_drive
);
  logic         rst_sync_n;
  logic [W-1:0] data_q, dir_q, pull_q, slew_q, drive_q;
  logic [W-1:0] sync_in;
  logic [W-1:0] per_en_m, ana_en_m;
  logic [W-1:0] pin_rd;

  gpio_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  gpio_regfile #(.W(W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .data_q  (data_q),
    .dir_q   (dir_q),
    .pull_q  (pull_q),
    .slew_q  (slew_q),
    .drive_q (drive_q)
  );

  gpio_in_sync #(.W(W)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d     (pad_in),
    .q     (sync_in)
  );

  always_comb begin
    per_en_m = per_en & {W{rst_sync_n}};
    ana_en_m = ana_en & {W{rst_sync_n}};
  end

  for (genvar i = 0; i < W; i++) begin : g_pin
    gpio_pin_mux #(.NO_INPUT(OUT_ONLY[i])) u_pin (
      .data    (data_q[i]),
      .dir     (dir_q[i]),
      .pull    (pull_q[i]),
      .per_en  (per_en_m[i]),
      .per_out (per_out[i]),
      .per_oe  (per_oe[i]),
      .ana_en  (ana_en_m[i]),
      .sync_in (sync_in[i]),
      .pad_out (pad_out[i]),
      .pad_oe  (pad_oe[i]),
      .pad_ie  (pad_ie[i]),
      .pad_pu  (pad_pu[i]),
      .rd_bit  (pin_rd[i])
    );
  end

  assign pad_slew  = slew_q;
  assign pad_drive = drive_q;

  always_comb begin
    case (addr)
      OFF_DATA:  rdata = pin_rd;
      OFF_DIR:   rdata = dir_q;
      OFF_PULL:  rdata = pull_q;
      OFF_SLEW:  rdata = slew_q;
      OFF_DRIVE: rdata = drive_q;
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_share_port_chk.sv
module gpio_share_port_chk #(
  parameter int unsigned W        = 8,
  parameter logic [W-1:0] OUT_ONLY = 8'h80
) (
  input logic         clk,
  input logic         rst_n,
  input logic         rst_sync_n,
  input logic         wr_en,
  input logic [2:0]   addr,
  input logic [W-1:0] wdata,
  input logic [W-1:0] dir_q,
  input logic [W-1:0] per_en,
  input logic [W-1:0] per_oe,
  input logic [W-1:0] ana_en,
  input logic [W-1:0] pad_oe,
  input logic [W-1:0] pad_ie,
  input logic [W-1:0] pad_pu
);
  a_r2_quiet_until_sync: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_sync_n |-> (pad_oe == '0) && (pad_ie == ~OUT_ONLY));

  a_r3_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_sync_n && wr_en && addr == 3'd1) |=> (dir_q == $past(wdata)));

  a_r4_oe_from_dir: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_sync_n && per_en == '0 && ana_en == '0) |-> (pad_oe == dir_q));

  a_r6_peripheral_oe: assert property (@(posedge clk) disable iff (!rst_n)
    rst_sync_n |-> ((pad_oe & per_en & ~ana_en) == (per_oe & per_en & ~ana_en)));

  a_r7_analog_isolates: assert property (@(posedge clk) disable iff (!rst_n)
    rst_sync_n |-> ((ana_en & (pad_oe | pad_ie)) == '0));

  a_r8_out_only_no_input: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_ie & OUT_ONLY) == '0);

  a_r9_pull_only_input: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pu & pad_oe) == '0);
endmodule

bind gpio_share_port gpio_share_port_chk #(.W(W), .OUT_ONLY(OUT_ONLY)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rst_sync_n (rst_sync_n),
  .wr_en      (wr_en),
  .addr       (addr),
  .wdata      (wdata),
  .dir_q      (dir_q),
  .per_en     (per_en),
  .per_oe     (per_oe),
  .ana_en     (ana_en),
  .pad_oe     (pad_oe),
  .pad_ie     (pad_ie),
  .pad_pu     (pad_pu)
);

// File: tb/gpio_share_port_bench.sv
`timescale 1ns/1ps
module gpio_share_port_bench;
  localparam int W = 8;
  localparam logic [W-1:0] OO = 8'h80;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [W-1:0] wdata = '0, per_en = '0, per_out = '0, per_oe = '0, ana_en = '0, pad_in = '0;
  logic [W-1:0] rdata, pad_out, pad_oe, pad_ie, pad_pu, pad_slew, pad_drive;

  int checks = 0;
  int errors = 0;
  bit go = 1'b0;

  always #4 clk = ~clk;

  gpio_share_port #(.W(W), .OUT_ONLY(OO)) u_gpio_share_port (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .per_en(per_en), .per_out(per_out), .per_oe(per_oe), .ana_en(ana_en), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_ie(pad_ie), .pad_pu(pad_pu),
    .pad_slew(pad_slew), .pad_drive(pad_drive));

  // Reference model state
  logic [W-1:0] m_reg [5];
  logic [W-1:0] m_s1 = '0, m_s2 = '0;
  logic m_rs1 = 1'b0, m_rs2 = 1'b0;
  initial for (int k = 0; k < 5; k++) m_reg[k] = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 5; k++) m_reg[k] <= '0;
      m_s1 <= '0; m_s2 <= '0; m_rs1 <= 1'b0; m_rs2 <= 1'b0;
    end else begin
      if (m_rs2 && wr_en && addr < 3'd5) m_reg[addr] <= wdata;
      if (m_rs2) begin m_s1 <= pad_in; m_s2 <= m_s1; end
      m_rs2 <= m_rs1;
      m_rs1 <= 1'b1;
    end
  end

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (go) begin
    logic [W-1:0] ana, dig, e_oe, e_out, e_ie, e_pu, e_rd;
    ana  = ana_en & {W{m_rs2}};
    dig  = per_en & ~ana & {W{m_rs2}};
    e_oe  = (dig & per_oe) | (~dig & ~ana & m_reg[1]);
    e_out = (dig & per_out) | (~dig & ~ana & m_reg[0]);
    e_ie  = ~ana & ~OO;
    e_pu  = m_reg[2] & ~e_oe & ~ana;
    if (addr == 3'd0) e_rd = (m_reg[1] & m_reg[0]) | (~m_reg[1] & m_s2 & e_ie);
    else if (addr < 3'd5) e_rd = m_reg[addr];
    else e_rd = '0;
    chk("R4 model pad_oe", pad_oe, e_oe);
    chk("R6 model pad_out", pad_out, e_out);
    chk("R8 model pad_ie", pad_ie, e_ie);
    chk("R9 model pad_pu", pad_pu, e_pu);
    chk("R10 model pad_slew", pad_slew, m_reg[3]);
    chk("R10 model pad_drive", pad_drive, m_reg[4]);
    chk((addr == 3'd0) ? "R5 model rdata" : "R3 model rdata", rdata, e_rd);
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [W-1:0] v);
    @(posedge clk); #1;
    wr_en = 1'b1; addr = a; wdata = v;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [W-1:0] exp);
    @(posedge clk); #1;
    addr = a;
    @(negedge clk);
    chk(req, rdata, exp);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R2: ownership inputs driven during reset and before synchronized release
    per_en = 8'hFF; per_oe = 8'hFF; per_out = 8'hFF; ana_en = 8'h0F;
    repeat (3) @(posedge clk);
    go = 1'b1;
    @(negedge clk);
    chk("R2 pad_oe in reset", pad_oe, 8'h00);
    chk("R2 pad_ie in reset", pad_ie, 8'h7F);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R2 pad_oe before sync release", pad_oe, 8'h00);
    @(posedge clk); #1;
    per_en = '0; per_oe = '0; per_out = '0; ana_en = '0;
    cyc(2);

    // R1: reset values
    rd_chk("R1 data", 3'd0, 8'h00);
    rd_chk("R1 dir", 3'd1, 8'h00);
    rd_chk("R1 pull", 3'd2, 8'h00);
    rd_chk("R1 slew", 3'd3, 8'h00);
    rd_chk("R1 drive", 3'd4, 8'h00);
    chk("R1 pad_oe", pad_oe, 8'h00);

    // R4: unowned pins follow direction and latch
    wr(3'd1, 8'h0F);
    wr(3'd0, 8'hA5);
    @(negedge clk);
    chk("R4 pad_oe", pad_oe, 8'h0F);
    chk("R4 pad_out", pad_out, 8'hA5);

    // R5: two-stage latency on inputs, latch on outputs
    addr = 3'd0; pad_in = 8'hBC;
    @(posedge clk); @(negedge clk);
    chk("R5 one edge after pad change", rdata, 8'h05);
    @(posedge clk); @(negedge clk);
    chk("R5 two edges after pad change", rdata, 8'h35);

    // R6: peripheral owns upper nibble
    @(posedge clk); #1;
    per_en = 8'hF0; per_out = 8'h50; per_oe = 8'hC0;
    @(negedge clk);
    chk("R6 pad_oe", pad_oe, 8'hCF);
    chk("R6 pad_out", pad_out, 8'h55);
    chk("R6 read follows dir", rdata, 8'h35);

    // R7: analog beats peripheral on bit 6, beats direction on bit 0
    @(posedge clk); #1;
    ana_en = 8'h41;
    @(negedge clk);
    chk("R7 pad_oe", pad_oe, 8'h8E);
    chk("R7 pad_ie", pad_ie, 8'h3E);
    chk("R7 pad_out", pad_out, 8'h14);

    // R8: disabled input buffer reads 0
    @(posedge clk); #1;
    pad_in = 8'hFF;
    cyc(2);
    @(negedge clk);
    chk("R8 analog and out-only bits read 0", rdata, 8'h35);

    // R9: pull-up gating
    wr(3'd2, 8'hFF);
    @(negedge clk);
    chk("R9 pad_pu", pad_pu, 8'h30);

    // R10: slew and drive
    wr(3'd3, 8'h5A);
    wr(3'd4, 8'hC3);
    @(negedge clk);
    chk("R10 pad_slew", pad_slew, 8'h5A);
    chk("R10 pad_drive", pad_drive, 8'hC3);

    // R3: unmapped offset stores nothing
    wr(3'd6, 8'hEE);
    rd_chk("R3 unmapped reads 0", 3'd6, 8'h00);
    rd_chk("R3 dir untouched", 3'd1, 8'h0F);
    rd_chk("R3 slew untouched", 3'd3, 8'h5A);

    // Same-cycle: direction write while the peripheral releases pins
    @(posedge clk); #1;
    wr_en = 1'b1; addr = 3'd1; wdata = 8'hF0; per_en = 8'h00; ana_en = 8'h00;
    @(negedge clk);
    chk("R4 old dir during write cycle", pad_oe, 8'h0F);
    @(posedge clk); #1;
    wr_en = 1'b0;
    @(negedge clk);
    chk("R4 new dir after write", pad_oe, 8'hF0);

    // Random phase: everything moves together, model judges each cycle
    for (int n = 0; n < 2000; n++) begin
      @(posedge clk); #1;
      wr_en = ($urandom % 3) == 0;
      addr = 3'($urandom);
      wdata = 8'($urandom);
      per_en = 8'($urandom); per_out = 8'($urandom); per_oe = 8'($urandom);
      ana_en = 8'($urandom) & 8'($urandom);
      pad_in = 8'($urandom);
    end

    // R1: mid-run reset
    @(posedge clk); #1;
    wr_en = 1'b0; per_en = '0; ana_en = '0;
    rst_n = 1'b0;
    #2;
    chk("R1 pad_oe on async reset", pad_oe, 8'h00);
    cyc(2);
    rst_n = 1'b1;
    cyc(3);
    rd_chk("R1 dir after reset", 3'd1, 8'h00);
    rd_chk("R1 pull after reset", 3'd2, 8'h00);
    rd_chk("R1 drive after reset", 3'd4, 8'h00);

    cyc(2);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule